// File: doc/BRIEF.md
# Configurable Level/Edge Event Router

The block watches a bank of up to 32 asynchronous event lines, such as wake pins, timer outputs, an encoder event or a reset request. It raises a sticky flag for each line whose trigger condition has been met. Each line has two configuration bits, a trigger kind and a polarity. Together they select one of four triggers: low level, high level, falling edge or rising edge. An enable mask then gates the flags into one interrupt line.

Software reaches the block through a small word-addressed register bus with a combinational read port. There are five registers: polarity, trigger kind, interrupt enable, a read-only flag register and a write-one-to-acknowledge register.

The acknowledge rule depends on the trigger kind. An edge-triggered flag clears as soon as it is acknowledged. A level-triggered flag stays set for as long as its line sits at the active level.

Top module: `event_router`

## Requirements
- R1: Each event line passes through two synchronising flops. A line change made just after a clock edge first shows in the flag register after the third following rising edge, and not after the second.
- R2: Per line n, kind bit 0 selects a level trigger and kind bit 1 selects an edge trigger. With a level trigger, polarity 0 means LOW and 1 means HIGH. With an edge trigger, polarity 0 means falling and 1 means rising.
- R3: With a level trigger, an acknowledge of flag n has no effect while line n is still at its active level. Once the line goes inactive, the flag stays set until it is acknowledged again.
- R4: With an edge trigger, an acknowledge clears flag n at once, even while the line holds its new level.
- R5: Flags are sticky. A flag falls only when a 1 is written to its bit of the acknowledge register. When a detection and an acknowledge land in the same cycle, the flag stays set.
- R6: `irq` is high exactly when some flag is set and its enable bit is 1. The enable register resets to zero.
- R7: While `rst_n` is low, the polarity, kind, enable and flag registers read 0 and `irq` is 0, so every line starts as a LOW-level trigger.
- R8: Bit n of every register belongs to line n. Bits cleared in `IMPL_MASK` are reserved: they read 0, ignore writes and never set a flag. The default mask reserves bits 18 and 20 to 31.
- R9: Register map by `bus_addr`: 0 polarity, 1 kind, 2 enable, 3 flags (read-only, writes ignored), 4 acknowledge (reads 0).
- R10: Changing a line's trigger configuration while the line is steady raises no flag. This holds for a switch from level to edge with the line at the new polarity's level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | N_IN | Asynchronous event lines |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | N_IN | Write data |
| bus_rdata | output | N_IN | Read data of the addressed register (combinational) |
| irq | output | 1 | OR of enabled flags |

## Verification
On every cycle the checker confirms the following:
- flags never drop without an acknowledge;
- a level line at its active level keeps its flag set;
- a detected edge always sets its flag, even against an acknowledge;
- an acknowledged edge flag with no new edge clears;
- reserved bits stay zero;
- `irq` stays low with nothing enabled.

Only the bench scenarios can show three things. The first is the exact three-edge latency from line to flag. The second is the full mode table under distinct before/after line patterns. The third is the register map behaviour: read-only flags, an acknowledge register that reads zero, and the absence of spurious flags when the configuration changes.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_POL  = 3'd0,
    REG_KIND = 3'd1,
    REG_ENA  = 3'd2,
    REG_FLAG = 3'd3,
    REG_ACK  = 3'd4
  } evr_reg_e;
endpackage

// File: rtl/evr_sync.sv
module evr_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        stab_q <= meta_q;
      end
    end

    assign sync_out[i] = stab_q;
  end
endmodule

// File: rtl/evr_detect.sv
module evr_detect #(
  parameter int unsigned    W    = 32,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_s,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] kind,
  output logic [W-1:0] prev,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q, prev_d;

  // Tracker follows the synchronised line each cycle, so after any
  // configuration write it already equals the current line value.
  always_comb prev_d = line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    if (MASK[i]) begin : g_live
      logic at_level, moved;
      always_comb begin
        at_level = ~(line_s[i] ^ pol[i]);
        moved    = line_s[i] ^ prev_q[i];
        hit[i]   = kind[i] ? (at_level & moved) : at_level;
      end
    end else begin : g_rsvd
      assign hit[i] = 1'b0;
    end
  end

  assign prev = prev_q;
endmodule

// File: rtl/evr_regs.sv
module evr_regs
  import evr_pkg::*;
#(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      flags,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      kind,
  output logic [W-1:0]      ena,
  output logic [W-1:0]      ack
);
  logic [W-1:0] pol_q, pol_d, kind_q, kind_d, ena_q, ena_d;

  always_comb begin
    pol_d  = pol_q;
    kind_d = kind_q;
    ena_d  = ena_q;
    ack    = '0;
    if (wr) begin
      case (addr)
        REG_POL:  pol_d  = wdata & MASK;
        REG_KIND: kind_d = wdata & MASK;
        REG_ENA:  ena_d  = wdata & MASK;
        REG_ACK:  ack    = wdata & MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      kind_q <= '0;
      ena_q  <= '0;
    end else begin
      pol_q  <= pol_d;
      kind_q <= kind_d;
      ena_q  <= ena_d;
    end
  end

  always_comb begin
    case (addr)
      REG_POL:  rdata = pol_q;
      REG_KIND: rdata = kind_q;
      REG_ENA:  rdata = ena_q;
      REG_FLAG: rdata = flags;
      default:  rdata = '0;
    endcase
  end

  assign pol  = pol_q;
  assign kind = kind_q;
  assign ena  = ena_q;
endmodule

// File: rtl/evr_status.sv
module evr_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] ack,
  input  logic [W-1:0] ena,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] flag_q, flag_d;

  // Detection is ORed in after the acknowledge, so a fresh hit (or a
  // level still held active) outlasts a same-cycle acknowledge.
  always_comb flag_d = (flag_q & ~ack) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & ena);
endmodule

// File: rtl/event_router.sv
module event_router
  import evr_pkg::*;
#(
  parameter int unsigned N_IN      = 32,
  parameter logic [31:0] IMPL_MASK = 32'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   ev_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_IN-1:0]   bus_wdata,
  output logic [N_IN-1:0]   bus_rdata,
  output logic              irq
);
  localparam logic [N_IN-1:0] MASK = IMPL_MASK[N_IN-1:0];

  logic [N_IN-1:0] sync_v, prev_v, hit_v;
  logic [N_IN-1:0] pol_q, kind_q, ena_q, ack_v, flag_q;

  evr_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ev_in), .sync_out(sync_v)
  );

  evr_detect #(.W(N_IN), .MASK(MASK)) u_det (
    .clk(clk), .rst_n(rst_n), .line_s(sync_v), .pol(pol_q),
    .kind(kind_q), .prev(prev_v), .hit(hit_v)
  );

  evr_regs #(.W(N_IN), .MASK(MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .flags(flag_q), .rdata(bus_rdata),
    .pol(pol_q), .kind(kind_q), .ena(ena_q), .ack(ack_v)
  );

  evr_status #(.W(N_IN)) u_stat (
    .clk(clk), .rst_n(rst_n), .hit(hit_v), .ack(ack_v), .ena(ena_q),
    .flags(flag_q), .irq(irq)
  );
endmodule

// File: rtl/evr_checker.sv
module evr_checker #(
  parameter int unsigned  N    = 32,
  parameter logic [N-1:0] MASK = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] flag_q,
  input logic [N-1:0] pol_q,
  input logic [N-1:0] kind_q,
  input logic [N-1:0] ena_q,
  input logic [N-1:0] sync_v,
  input logic [N-1:0] prev_v,
  input logic [N-1:0] ack_v,
  input logic         irq
);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q) & ~flag_q & ~$past(ack_v)) == '0));

  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~kind_q & ~(sync_v ^ pol_q) & MASK) & ~flag_q) == '0));

  assert_edge_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(kind_q & (sync_v ^ prev_v) & ~(sync_v ^ pol_q) & MASK)
               & ~flag_q) == '0));

  assert_edge_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ack_v & kind_q &
                     ~((sync_v ^ prev_v) & ~(sync_v ^ pol_q))) & flag_q) == '0));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q | pol_q | kind_q | ena_q) & ~MASK) == '0);

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq);
endmodule

bind event_router evr_checker #(.N(N_IN), .MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .pol_q(pol_q),
  .kind_q(kind_q), .ena_q(ena_q), .sync_v(sync_v), .prev_v(prev_v),
  .ack_v(ack_v), .irq(irq)
);

// File: tb/tb_event_router.sv
module tb_event_router;
  localparam int unsigned N  = 32;
  localparam logic [31:0] MK = 32'h000B_FFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ev_in;
  logic [2:0]    bus_addr;
  logic          bus_wr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  event_router #(.N_IN(N), .IMPL_MASK(MK)) dut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  // Fields: kind, pol, line before, line after, expected flag.
  localparam logic [4:0] VECS [10] = '{
    5'b00101, 5'b00110, 5'b01011, 5'b01000, 5'b10101,
    5'b10000, 5'b10010, 5'b11011, 5'b11100, 5'b11110
  };

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    ev_in = '1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    tick(3);
    // R7: reset state
    rd(3'd0, v); check("R7 polarity reset", v, '0);
    rd(3'd3, v); check("R7 flags reset", v, '0);
    check("R7 irq reset", {{(N-1){1'b0}}, irq}, '0);
    @(negedge clk); rst_n = 1'b1;
    tick(5);
    // Synchroniser starts at 0: every live LOW-level line flags once (R7, R8).
    rd(3'd3, v); check("R8 only live bits flag after reset", v, MK);
    wr(3'd4, '1);
    rd(3'd3, v); check("R7 flags clear with lines high", v, '0);

    // R1: latency of exactly three edges
    ev_in[5] = 1'b0;
    tick(2);
    rd(3'd3, v); check("R1 no flag after two edges", v, '0);
    tick();
    rd(3'd3, v); check("R1 flag after three edges", v, 32'h20);
    ev_in[5] = 1'b1; tick(3); wr(3'd4, '1);

    // R2: mode table on line 0
    foreach (VECS[k]) begin
      logic e, p, b, a, x;
      {e, p, b, a, x} = VECS[k];
      wr(3'd0, {{(N-1){1'b0}}, p});
      wr(3'd1, {{(N-1){1'b0}}, e});
      ev_in[0] = b; tick(4);
      wr(3'd4, 32'h1);
      ev_in[0] = a; tick(4);
      rd(3'd3, v);
      check($sformatf("R2 mode vector %0d", k), {{(N-1){1'b0}}, v[0]},
            {{(N-1){1'b0}}, x});
    end
    wr(3'd0, '0); wr(3'd1, '0); ev_in[0] = 1'b1; tick(4); wr(3'd4, '1);

    // R3: level HIGH on line 5 refuses acknowledge while active
    wr(3'd0, 32'h20);
    ev_in[5] = 1'b1; tick(4);
    wr(3'd4, 32'h20);
    rd(3'd3, v); check("R3 ack ignored while active", v & 32'h20, 32'h20);
    ev_in[5] = 1'b0; tick(4);
    rd(3'd3, v); check("R5 flag sticky after line inactive", v & 32'h20, 32'h20);
    wr(3'd4, 32'h20);
    rd(3'd3, v); check("R3 ack after inactive clears", v & 32'h20, '0);

    // R4: rising edge, acknowledge while line stays high
    wr(3'd1, 32'h20);
    ev_in[5] = 1'b1; tick(4);
    rd(3'd3, v); check("R4 rising edge flags", v & 32'h20, 32'h20);
    wr(3'd4, 32'h20); tick(3);
    rd(3'd3, v); check("R4 edge ack clears with line high", v & 32'h20, '0);

    // R5: detection and acknowledge in the same cycle
    ev_in[5] = 1'b0; tick(4); wr(3'd4, '1);
    ev_in[5] = 1'b1; tick(2);
    wr(3'd4, 32'h20);
    rd(3'd3, v); check("R5 set wins over ack", v & 32'h20, 32'h20);

    // R6: interrupt gating
    check("R6 irq low with enable zero", {{(N-1){1'b0}}, irq}, '0);
    wr(3'd2, 32'h20);
    check("R6 irq high with enabled flag", {{(N-1){1'b0}}, irq}, 32'h1);
    wr(3'd4, 32'h20);
    check("R6 irq low after ack", {{(N-1){1'b0}}, irq}, '0);
    wr(3'd2, '0);

    // R8: reserved configuration bits
    wr(3'd0, '1);
    rd(3'd0, v); check("R8 reserved polarity bits read 0", v, MK);
    wr(3'd0, '0);
    ev_in[18] = 1'b0; tick(4);
    rd(3'd3, v); check("R8 reserved line never flags", v & ~MK, '0);
    ev_in[18] = 1'b1;

    // R9: flag register read-only, acknowledge reads 0
    wr(3'd1, 32'h0); tick(4); wr(3'd4, '1);
    wr(3'd3, '1);
    rd(3'd3, v); check("R9 flag write ignored", v, '0);
    rd(3'd4, v); check("R9 ack reads zero", v, '0);

    // R10: level-LOW to rising edge with line steady high
    wr(3'd1, 32'h20);
    wr(3'd0, 32'h20);
    tick(4);
    rd(3'd3, v); check("R10 no flag on mode change", v & 32'h20, '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule